// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a small table of four entries. Each entry is a two-bit state machine. Two bits of the branch address, just above the byte offset of a word-aligned instruction, select one entry. The fetch side presents an address on the lookup port and gets a taken / not-taken guess back in the same cycle. When the branch resolves, the execute side presents the same address and the real outcome on the update port, and the selected entry steps to its next state.

The state machine is not a plain saturating counter. Its four states are `ST_STRONG_NT` (00), `ST_WEAK_NT` (01), `ST_WEAK_T` (10) and `ST_STRONG_T` (11). The two `_NT` states guess not taken and the two `_T` states guess taken. The transitions are:

- `ST_STRONG_NT`: taken goes to `ST_WEAK_NT`; not taken stays.
- `ST_WEAK_NT`: taken jumps to `ST_STRONG_T`; not taken goes back to `ST_STRONG_NT`.
- `ST_WEAK_T`: taken goes to `ST_STRONG_T`; not taken drops all the way to `ST_STRONG_NT`.
- `ST_STRONG_T`: taken stays; not taken goes to `ST_WEAK_T`.

A counter records every update whose real outcome disagrees with the guess the entry held before that update.

Top module: `bp_direction_predictor`

## Requirements
- R1: After a synchronous reset, every entry is in state 00, so a lookup at any address predicts not taken, and `miss_count` is 0.
- R2: The entry index is address bits [3:2], and all other address bits are ignored. For example, 0x14 and 0x04 both select entry 1.
- R3: `lkp_taken` is 1 when the indexed entry is in state 10 or 11, and 0 when it is in state 00 or 01.
- R4: From state 00, a taken update moves the entry to 01, and a not-taken update leaves it at 00.
- R5: From state 01, a taken update moves the entry to 11, and a not-taken update moves it to 00.
- R6: From state 10, a taken update moves the entry to 11, and a not-taken update moves it to 00.
- R7: From state 11, a taken update leaves the entry at 11, and a not-taken update moves it to 10.
- R8: An update changes only the entry it indexes, and only on a clock edge where `upd_valid` is 1. With `upd_valid` at 0, `upd_pc` and `upd_taken` have no effect.
- R9: The lookup is combinational. When a lookup and an update select the same entry in the same cycle, the lookup returns the guess from the state before the update.
- R10: On a valid update, `miss_count` increases by exactly one if `upd_taken` differs from the entry's pre-update guess, and stays the same otherwise. It wraps modulo 2^CNT_W.
- R11: Reset is sampled on the clock edge and takes priority over a valid update in the same cycle. After that edge, all entries are 00 and the count is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lkp_pc | input | PC_W | Address of the branch being looked up |
| lkp_taken | output | 1 | Guess for the lookup address: 1 = taken |
| upd_valid | input | 1 | Update request strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch: 1 = taken |
| miss_count | output | CNT_W | Number of mispredicted updates since reset |

## Verification
The assertions assume that `upd_valid`, `upd_taken` and `upd_pc` are known values on every edge outside reset. They also assume that the slot vector they observe starts from the reset state, so each transition check compares against one step of the table. The bench drives every input on the falling edge and holds it stable through the next rising edge. It walks one entry through every state and both outcomes, replaying the same entry through an aliased address. It also overlaps lookups with updates to the same entry, issues invalid updates that carry taken outcomes, and asserts reset together with a valid update. This keeps each checked transition to one well-defined edge.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Two-bit direction state held by each table entry.
    typedef enum logic [1:0] {
        ST_STRONG_NT = 2'b00,
        ST_WEAK_NT   = 2'b01,
        ST_WEAK_T    = 2'b10,
        ST_STRONG_T  = 2'b11
    } bp_state_t;

endpackage

// File: rtl/bp_state_next.sv
// Next-state function of one predictor entry (R4..R7).
module bp_state_next
    import bp_pkg::*;
(
    input  bp_state_t cur,
    input  logic      taken,
    output bp_state_t nxt
);

    always_comb begin
        unique case (cur)
            ST_STRONG_NT: nxt = taken ? ST_WEAK_NT  : ST_STRONG_NT;  // R4
            ST_WEAK_NT:   nxt = taken ? ST_STRONG_T : ST_STRONG_NT;  // R5
            ST_WEAK_T:    nxt = taken ? ST_STRONG_T : ST_STRONG_NT;  // R6
            ST_STRONG_T:  nxt = taken ? ST_STRONG_T : ST_WEAK_T;     // R7
            default:      nxt = ST_STRONG_NT;
        endcase
    end

endmodule

// File: rtl/bp_slot_array.sv
// Table of direction-state entries with one read port for lookup
// and one read-modify-write port for update.
module bp_slot_array
    import bp_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic                  wr_taken,
    input  logic [IDX_W-1:0]      rd_idx,
    output bp_state_t             rd_state,
    output bp_state_t             wr_state,
    output logic [2*(1<<IDX_W)-1:0] slot_vec
);

    localparam int SLOTS = 1 << IDX_W;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        bp_state_t st_q;
        bp_state_t st_d;
        logic      hit;

        assign hit = wr_en && (wr_idx == IDX_W'(g));

        bp_state_next u_next (
            .cur   (st_q),
            .taken (wr_taken),
            .nxt   (st_d)
        );

        // State register: reset has priority over update (R11).
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q <= ST_STRONG_NT;
            end else if (hit) begin
                st_q <= st_d;
            end
        end

        assign slot_vec[2*g +: 2] = st_q;
    end

    // Pre-update read for both ports (R9).
    assign rd_state = bp_state_t'(slot_vec[rd_idx*2 +: 2]);
    assign wr_state = bp_state_t'(slot_vec[wr_idx*2 +: 2]);

endmodule

// File: rtl/bp_miss_counter.sv
// Counts mispredicted updates; wraps at its width (R10).
module bp_miss_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (bump) begin
            count <= count + STEP;
        end
    end

endmodule

// File: rtl/bp_direction_predictor.sv
module bp_direction_predictor
    import bp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int IDX_LSB = 2,
    parameter int IDX_W   = 2,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PC_W-1:0]  lkp_pc,
    output logic             lkp_taken,
    input  logic             upd_valid,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic             upd_taken,
    output logic [CNT_W-1:0] miss_count
);

    localparam int SLOTS  = 1 << IDX_W;
    localparam int IDX_HI = IDX_LSB + IDX_W;

    logic [IDX_W-1:0]     lkp_idx;
    logic [IDX_W-1:0]     upd_idx;
    bp_state_t            lkp_state;
    bp_state_t            upd_state;
    logic [2*SLOTS-1:0]   slot_vec;
    logic                 upd_pred;
    logic                 miss_bump;
    logic                 unused_pc_bits;

    // Index selection (R2).
    assign lkp_idx = lkp_pc[IDX_LSB +: IDX_W];
    assign upd_idx = upd_pc[IDX_LSB +: IDX_W];

    generate
        if (IDX_LSB > 0 && IDX_HI < PC_W) begin : g_unused_both
            assign unused_pc_bits = ^{lkp_pc[PC_W-1:IDX_HI], lkp_pc[IDX_LSB-1:0],
                                      upd_pc[PC_W-1:IDX_HI], upd_pc[IDX_LSB-1:0]};
        end else if (IDX_HI < PC_W) begin : g_unused_hi
            assign unused_pc_bits = ^{lkp_pc[PC_W-1:IDX_HI], upd_pc[PC_W-1:IDX_HI]};
        end else if (IDX_LSB > 0) begin : g_unused_lo
            assign unused_pc_bits = ^{lkp_pc[IDX_LSB-1:0], upd_pc[IDX_LSB-1:0]};
        end else begin : g_unused_none
            assign unused_pc_bits = 1'b0;
        end
    endgenerate

    bp_slot_array #(.IDX_W(IDX_W)) u_slots (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken),
        .rd_idx   (lkp_idx),
        .rd_state (lkp_state),
        .wr_state (upd_state),
        .slot_vec (slot_vec)
    );

    // Output process: guess from the looked-up state (R3, R9).
    always_comb begin
        unique case (lkp_state)
            ST_STRONG_NT, ST_WEAK_NT: lkp_taken = 1'b0;
            ST_WEAK_T, ST_STRONG_T:   lkp_taken = 1'b1;
            default:                  lkp_taken = 1'b0;
        endcase
    end

    // Pre-update guess of the entry being updated (R10).
    always_comb begin
        unique case (upd_state)
            ST_STRONG_NT, ST_WEAK_NT: upd_pred = 1'b0;
            ST_WEAK_T, ST_STRONG_T:   upd_pred = 1'b1;
            default:                  upd_pred = 1'b0;
        endcase
    end

    assign miss_bump = upd_valid && (upd_taken != upd_pred);

    bp_miss_counter #(.CNT_W(CNT_W)) u_miss (
        .clk   (clk),
        .rst   (rst),
        .bump  (miss_bump),
        .count (miss_count)
    );

endmodule

// File: rtl/bp_predictor_chk.sv
module bp_predictor_chk #(
    parameter int IDX_W = 2,
    parameter int CNT_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    upd_valid,
    input logic                    upd_taken,
    input logic [IDX_W-1:0]        upd_idx,
    input logic [1:0]              upd_state,
    input logic [2*(1<<IDX_W)-1:0] slot_vec,
    input logic [CNT_W-1:0]        miss_count
);

    logic [IDX_W-1:0] idx_d;
    logic [1:0]       slot_after;
    logic             prev_rst = 1'b0;

    always_ff @(posedge clk) idx_d <= upd_idx;
    assign slot_after = slot_vec[idx_d*2 +: 2];

    // R11
    always @(posedge clk) begin
        if (prev_rst) begin
            rst_clears_chk: assert (miss_count == '0 && slot_vec == '0);
        end
        prev_rst <= rst;
    end

    // R4
    weak_nt_entry_chk: assert property (@(posedge clk) disable iff (rst)
        upd_valid && upd_state == 2'b00 && upd_taken |=> slot_after == 2'b01);

    // R5
    weak_nt_jump_chk: assert property (@(posedge clk) disable iff (rst)
        upd_valid && upd_state == 2'b01 && upd_taken |=> slot_after == 2'b11);

    // R6
    weak_t_drop_chk: assert property (@(posedge clk) disable iff (rst)
        upd_valid && upd_state == 2'b10 && !upd_taken |=> slot_after == 2'b00);

    // R7
    strong_t_decay_chk: assert property (@(posedge clk) disable iff (rst)
        upd_valid && upd_state == 2'b11 && !upd_taken |=> slot_after == 2'b10);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(slot_vec) && $stable(miss_count));

    // R10
    miss_step_chk: assert property (@(posedge clk) disable iff (rst)
        upd_valid && (upd_taken != upd_state[1]) |=> miss_count == $past(miss_count) + 1'b1);

    // R10
    hit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        upd_valid && (upd_taken == upd_state[1]) |=> $stable(miss_count));

endmodule

bind bp_direction_predictor bp_predictor_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .upd_idx    (upd_idx),
    .upd_state  (upd_state),
    .slot_vec   (slot_vec),
    .miss_count (miss_count)
);

// File: tb/bp_direction_predictor_test.sv
`timescale 1ns/1ps
module bp_direction_predictor_test;

    localparam int PC_W  = 32;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b0;
    logic [PC_W-1:0]  lkp_pc = '0;
    logic             lkp_taken;
    logic             upd_valid = 1'b0;
    logic [PC_W-1:0]  upd_pc = '0;
    logic             upd_taken = 1'b0;
    logic [CNT_W-1:0] miss_count;

    always #5 clk = ~clk;

    bp_direction_predictor #(.PC_W(PC_W), .CNT_W(CNT_W)) uut (
        .clk        (clk),
        .rst        (rst),
        .lkp_pc     (lkp_pc),
        .lkp_taken  (lkp_taken),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken),
        .miss_count (miss_count)
    );

    typedef struct {
        bit          chk_lkp;
        bit          exp_lkp;
        int unsigned exp_cnt;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    int          checks = 0;
    int          failures = 0;
    int          model[4];
    int unsigned model_cnt = 0;
    bit          done = 0;

    function automatic int nxt_state(int s, bit t);
        case (s)
            0: return t ? 1 : 0;
            1: return t ? 3 : 0;
            2: return t ? 3 : 0;
            default: return t ? 3 : 2;
        endcase
    endfunction

    // Driver: drive at the falling edge, push the expectation.
    task automatic step(input bit r, input logic [PC_W-1:0] lpc, input bit uv,
                        input logic [PC_W-1:0] upc, input bit ut,
                        input bit chk, input string tag);
        item_t it;
        int li;
        int ui;
        @(negedge clk);
        rst = r; lkp_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
        li = int'(lpc[3:2]);
        ui = int'(upc[3:2]);
        it.chk_lkp = chk;
        it.exp_lkp = (model[li] >= 2);
        if (r) begin
            for (int k = 0; k < 4; k++) model[k] = 0;
            model_cnt = 0;
        end else if (uv) begin
            if (ut != (model[ui] >= 2)) model_cnt++;
            model[ui] = nxt_state(model[ui], ut);
        end
        it.exp_cnt = model_cnt & 32'hFFFF;
        it.tag = tag;
        #1;
        sb_q.push_back(it);
    endtask

    // Monitor: compare lookup before the edge, count after it.
    initial begin
        item_t it;
        forever begin
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            if (it.chk_lkp) begin
                checks++;
                if (lkp_taken !== it.exp_lkp) begin
                    failures++;
                    $display("FAIL %s lkp_taken actual=%b expected=%b", it.tag, lkp_taken, it.exp_lkp);
                end
            end
            @(posedge clk);
            #1;
            checks++;
            if (miss_count !== CNT_W'(it.exp_cnt)) begin
                failures++;
                $display("FAIL %s miss_count actual=%0d expected=%0d", it.tag, miss_count, it.exp_cnt);
            end
        end
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) model[k] = 0;
        step(1, 32'h0, 0, 32'h0, 0, 0, "R11 reset");
        // R1: every slot not taken after reset
        step(0, 32'h0, 0, 32'h0, 0, 1, "R1 slot0");
        step(0, 32'h4, 0, 32'h0, 0, 1, "R1 slot1");
        step(0, 32'h8, 0, 32'h0, 0, 1, "R1 slot2");
        step(0, 32'hC, 0, 32'h0, 0, 1, "R1 slot3");
        // R4 / R5 / R9 on slot 1 via 0x14
        step(0, 32'h14, 1, 32'h14, 1, 1, "R9 R4 00 taken");
        step(0, 32'h14, 1, 32'h14, 1, 1, "R3 R5 01 taken");
        step(0, 32'h14, 0, 32'h0, 0, 1, "R3 state 11");
        step(0, 32'h14, 1, 32'h14, 1, 1, "R7 11 taken");
        step(0, 32'h14, 1, 32'h14, 0, 1, "R7 11 not taken");
        step(0, 32'h14, 0, 32'h0, 0, 1, "R3 state 10");
        step(0, 32'h14, 1, 32'h14, 1, 1, "R6 10 taken");
        step(0, 32'h14, 1, 32'h14, 0, 1, "R10 11 nt miss");
        step(0, 32'h04, 1, 32'hF004, 0, 1, "R2 R6 10 not taken alias");
        step(0, 32'h1234_0004, 0, 32'h0, 0, 1, "R2 alias lookup state 00");
        step(0, 32'h14, 1, 32'h14, 0, 1, "R4 00 not taken");
        step(0, 32'h14, 1, 32'h14, 1, 1, "R4 00 taken again");
        step(0, 32'h14, 1, 32'h14, 0, 1, "R5 01 not taken");
        // R8: invalid updates ignored, other slots untouched
        step(0, 32'h18, 0, 32'h18, 1, 1, "R8 idle taken");
        step(0, 32'h18, 0, 32'h18, 1, 1, "R8 idle again");
        step(0, 32'h08, 1, 32'h08, 1, 1, "R8 slot2 train");
        step(0, 32'h08, 1, 32'h08, 1, 1, "R8 slot2 train2");
        step(0, 32'h08, 0, 32'h0, 0, 1, "R8 slot2 taken");
        step(0, 32'h00, 0, 32'h0, 0, 1, "R8 slot0 untouched");
        step(0, 32'h0C, 0, 32'h0, 0, 1, "R8 slot3 untouched");
        step(0, 32'h04, 0, 32'h0, 0, 1, "R8 slot1 untouched");
        // R9: lookup slot2 while updating it not taken
        step(0, 32'h28, 1, 32'h08, 0, 1, "R9 same slot pre-state");
        step(0, 32'h08, 0, 32'h0, 0, 1, "R9 post state 10");
        // R11: reset wins over update
        step(1, 32'h08, 1, 32'h08, 1, 1, "R11 reset with update");
        step(0, 32'h08, 0, 32'h0, 0, 1, "R11 slot2 cleared");
        step(0, 32'h08, 1, 32'h08, 1, 1, "R10 after reset miss");
        step(0, 32'h0, 0, 32'h0, 0, 1, "R10 idle");
        wait (sb_q.size() == 0);
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule